// File: doc/BRIEF.md
# Multi-Mode Addressable Bit Latch

A bank of single-bit storage cells reached through a binary address, with one serial data input and two active-low controls that together choose among four behaviours: write one addressed cell, hold every cell, steer the data input onto a single output line with all others forced low (a demultiplexer, or an active-high one-of-N decoder when the data input is tied high), and force every output low. The stored cells are flip-flops sampled on the rising clock edge. The parallel outputs come from a per-mode selector, so the demultiplexer and clear behaviours override what is stored.

Typical uses are serial-to-parallel loading (present one bit per cycle at addresses 0 up to N-1), sparse control-bit registers where only one bit changes at a time, and address decoding. A registered protocol flag reports address changes while the latch enable stays low in two consecutive cycles, since in a latch-based build such a change could disturb a bit that was not meant to be written.

Top module: `bitlatch_bank`

## Requirements
- R1: While `rst` is high at a rising edge, every stored bit and `addr_err` are cleared, so with the controls in hold the outputs read all zeros afterwards.
- R2: With `le_n`=0 and `clr_n`=1 (write), the rising edge loads `din` into the cell selected by `addr` and leaves every other cell unchanged.
- R3: In write mode, `q` shows the stored bits except that the addressed bit shows `din` in the same cycle.
- R4: With `le_n`=1 and `clr_n`=1 (hold), no cell changes and `q` shows the stored bits whatever `din` and `addr` do.
- R5: With `le_n`=0 and `clr_n`=0 (demultiplexer), the addressed bit of `q` equals `din` and all others are 0; with `din`=1 the output is the one-hot decode of `addr`.
- R6: With `le_n`=1 and `clr_n`=0 (clear), `q` is all zeros regardless of `addr` and `din`.
- R7: Any rising edge with `clr_n`=0 (demultiplexer or clear) clears all stored cells, so a following hold shows zeros.
- R8: The address is binary with `addr[0]` least significant: value k selects `q[k]`.
- R9: `addr_err` goes high for the cycle after an edge at which `le_n` was 0 and had also been 0 at the preceding edge with a different `addr`; otherwise it is 0.
- R10: Writing bits to addresses 0 through N-1 in N consecutive write cycles makes all N bits appear together on `q` in the following hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| le_n | input | 1 | Latch enable, active low |
| clr_n | input | 1 | Clear control, active low |
| addr | input | ADDR_W | Binary cell address |
| din | input | 1 | Serial data input |
| q | output | 2**ADDR_W | Parallel outputs |
| addr_err | output | 1 | One-cycle flag for an address change with the enable held low |

## Verification
The assertions assume `rst` is high from the first edge and that the controls and address are settled before each rising edge, which the bench ensures by changing every input only at the falling edge. The bench deliberately breaks the address rule during the demultiplexer sweep and the serial load, so the protocol-flag assertion is written as a cause check that holds whether or not the rule is kept; the storage assertions make no assumption on the address.

// File: rtl/bitlatch_bank.sv
module bitlatch_bank #(
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    le_n,
  input  logic                    clr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    din,
  output logic [(1<<ADDR_W)-1:0]  q,
  output logic                    addr_err
);
  localparam int NBITS = 1 << ADDR_W;

  logic [NBITS-1:0]  store;
  logic [NBITS-1:0]  sel;
  logic [ADDR_W-1:0] last_addr;
  logic              last_en;

  wire wr_mode   = !le_n &&  clr_n;
  wire hold_mode =  le_n &&  clr_n;
  wire dmx_mode  = !le_n && !clr_n;
  wire clr_mode  =  le_n && !clr_n;

  assign sel = NBITS'(1) << addr;

  always_ff @(posedge clk) begin
    if (rst)             store <= '0;
    else if (!clr_n)     store <= '0;
    else if (wr_mode)    store <= (store & ~sel) | (sel & {NBITS{din}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_en   <= 1'b0;
      last_addr <= '0;
      addr_err  <= 1'b0;
    end else begin
      last_en   <= !le_n;
      last_addr <= addr;
      addr_err  <= !le_n && last_en && (addr != last_addr);
    end
  end

  always_comb begin
    unique case ({le_n, clr_n})
      2'b01:   q = (store & ~sel) | (sel & {NBITS{din}});
      2'b11:   q = store;
      2'b00:   q = sel & {NBITS{din}};
      default: q = '0;
    endcase
  end

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (store == '0) && !addr_err);

  p_write_only_sel_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_mode)) |-> (((store ^ $past(store)) & ~$past(sel)) == '0));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (hold_mode && !$past(rst) && $past(hold_mode)) |-> $stable(q));

  p_demux_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    dmx_mode |-> ($onehot0(q) && ((q & ~sel) == '0)));

  p_clear_out_r6: assert property (@(posedge clk) disable iff (rst)
    clr_mode |-> (q == '0));

  p_wipe_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr_n)) |-> (store == '0));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (!$past(le_n) && ($past(addr) != $past(addr, 2))));
endmodule

// File: tb/bitlatch_bank_tb_top.sv
`timescale 1ns/1ps
module bitlatch_bank_tb_top;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic le_n = 1'b1, clr_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0] q;
  logic addr_err;

  int total = 0;
  int bad = 0;

  logic [N-1:0]  m_store = '0, p_store = '0;
  logic          m_err = 1'b0, p_err = 1'b0;
  logic          m_en = 1'b0, p_en = 1'b0;
  logic [AW-1:0] m_addr = '0, p_addr = '0;
  logic [N-1:0]  exp_q;

  always #4 clk = ~clk;

  bitlatch_bank #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .le_n(le_n), .clr_n(clr_n),
    .addr(addr), .din(din), .q(q), .addr_err(addr_err)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic le, input logic cl, input logic [AW-1:0] a, input logic d);
    logic [N-1:0] s;
    @(negedge clk);
    m_store = p_store; m_err = p_err; m_en = p_en; m_addr = p_addr;
    rst = r; le_n = le; clr_n = cl; addr = a; din = d;
    #1;
    s = N'(1) << a;
    case ({le, cl})
      2'b01:   exp_q = (m_store & ~s) | (s & {N{d}});
      2'b11:   exp_q = m_store;
      2'b00:   exp_q = s & {N{d}};
      default: exp_q = '0;
    endcase
    if (r || !cl)   p_store = '0;
    else if (!le)   p_store = (m_store & ~s) | (s & {N{d}});
    else            p_store = m_store;
    p_err  = !r && !le && m_en && (a != m_addr);
    p_en   = !r && !le;
    p_addr = a;
  endtask

  task automatic t_reset;
    step(1, 1, 1, 3'd0, 0);
    step(1, 1, 1, 3'd0, 0);
    step(0, 1, 1, 3'd0, 0);
    chk("R1 q after reset", q, '0);
    chk("R1 addr_err after reset", N'(addr_err), '0);
  endtask

  task automatic t_write;
    step(0, 0, 1, 3'd5, 1);
    chk("R3 R8 write shows din at q[5]", q, 8'h20);
    step(0, 1, 1, 3'd1, 1);
    chk("R2 only q[5] stored", q, 8'h20);
    step(0, 0, 1, 3'd2, 1);
    chk("R3 write q[2] transparent", q, 8'h24);
    step(0, 1, 1, 3'd7, 0);
    chk("R2 q[2] stored, q[5] kept", q, 8'h24);
    step(0, 0, 1, 3'd5, 0);
    chk("R3 clearing q[5] visible", q, 8'h04);
    step(0, 1, 1, 3'd0, 1);
    chk("R2 q[5] cleared, q[2] kept", q, 8'h04);
  endtask

  task automatic t_hold;
    for (int i = 0; i < N; i++) begin
      step(0, 1, 1, AW'(i), i[0]);
      chk("R4 hold ignores addr and din", q, 8'h04);
    end
    chk("R4 no flag in hold", N'(addr_err), '0);
  endtask

  task automatic t_demux;
    step(0, 0, 0, 3'd3, 1);
    chk("R5 demux q[3]=din=1", q, 8'h08);
    step(0, 0, 0, 3'd3, 0);
    chk("R5 demux din=0 all low", q, '0);
    for (int i = 0; i < N; i++) begin
      step(0, 0, 0, AW'(i), 1);
      chk("R5 R8 decoder one-hot", q, exp_q);
      chk("R8 decode of address", q, N'(1) << i);
    end
    step(0, 1, 1, 3'd0, 0);
    chk("R7 hold after demux shows cleared", q, '0);
  endtask

  task automatic t_clear;
    step(0, 0, 1, 3'd6, 1);
    step(0, 1, 1, 3'd6, 1);
    step(0, 0, 1, 3'd1, 1);
    step(0, 1, 1, 3'd1, 1);
    chk("R2 setup before clear", q, 8'h42);
    step(0, 1, 0, 3'd6, 1);
    chk("R6 clear forces zeros", q, '0);
    step(0, 1, 0, 3'd1, 0);
    chk("R6 clear ignores addr/din", q, '0);
    step(0, 1, 1, 3'd6, 1);
    chk("R7 hold after clear shows zeros", q, '0);
  endtask

  task automatic t_flag;
    step(0, 1, 1, 3'd0, 0);
    step(0, 0, 1, 3'd1, 1);
    step(0, 0, 1, 3'd1, 1);
    chk("R9 first write cycle no flag", N'(addr_err), '0);
    step(0, 0, 1, 3'd6, 0);
    chk("R9 same address no flag", N'(addr_err), '0);
    step(0, 1, 1, 3'd6, 0);
    chk("R9 flag after address change", N'(addr_err), N'(1));
    step(0, 1, 1, 3'd2, 0);
    chk("R9 flag lasts one cycle", N'(addr_err), '0);
    chk("R9 bench model agrees", N'(addr_err), N'(m_err));
    chk("R2 flag test stored bits", q, 8'h02);
  endtask

  task automatic t_serial;
    logic [N-1:0] pat;
    pat = 8'hB5;
    for (int i = 0; i < N; i++) begin
      step(0, 0, 1, AW'(i), pat[i]);
      if (i >= 2) chk("R9 flag during serial load", N'(addr_err), N'(1));
    end
    step(0, 1, 1, 3'd0, 0);
    chk("R10 serial word appears", q, pat);
    step(0, 0, 0, 3'd0, 0);
    step(0, 1, 1, 3'd0, 0);
    pat = 8'h5A;
    for (int i = 0; i < N; i++) step(0, 0, 1, AW'(i), pat[i]);
    step(0, 1, 1, 3'd4, 1);
    chk("R10 second serial word", q, pat);
  endtask

  task automatic t_rereset;
    step(1, 1, 1, 3'd0, 0);
    step(0, 1, 1, 3'd0, 0);
    chk("R1 reset clears stored word", q, '0);
  endtask

  initial begin
    t_reset();
    t_write();
    t_hold();
    t_demux();
    t_clear();
    t_flag();
    t_serial();
    t_rereset();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule